// File: doc/BRIEF.md
# Banked Program Counter Unit

This block holds the 12-bit fetch address of a small 8-bit controller whose program memory is split into two 2K banks. Address bit 11 picks the bank. It is not changed by counting. Instead, bit 11 comes from a pending bank flag. Two bank-select strobes set or clear that flag, and the flag is copied into bit 11 only when a jump or call is taken. The low eleven bits count through the current bank and wrap inside it.

An eight-entry circular return stack stores full 12-bit addresses for calls and interrupt entries. A return therefore lands in the right bank. Interrupt entry sends the counter to one of two fixed low vectors in bank 0 and raises an in-service flag. While that flag is up, bit 11 is held at zero. Bank selects issued inside the service routine still change the pending flag. A return-with-restore strobe brings back the full saved address and drops the in-service flag.

The instruction decoder drives the block with one-cycle strobes. Every strobe takes effect at the next rising clock edge.

Top module: `bank_pc_unit`

## Requirements
- R1: After reset, fetchAddr is 000h, inService is 0 and the pending bank flag is 0, so a first jump lands in bank 0.
- R2: selBank1 sets the pending bank flag and selBank0 clears it. If both are high in one cycle, selBank1 wins. A bank select alone leaves fetchAddr unchanged. A jump or call in the same cycle uses the flag value from before that cycle.
- R3: A jump or call loads fetchAddr with the pending bank flag in bit 11 and branchTarget in bits 10..0. A call also pushes {fetchAddr[11], fetchAddr[10:0]+1 modulo 2048}.
- R4: An increment adds 1 to bits 10..0, wrapping 7FFh to 000h, and leaves bit 11 unchanged.
- R5: A plain return pops the last pushed 12-bit address into fetchAddr and leaves the pending bank flag unchanged.
- R6: Interrupt entry pushes the current fetchAddr, loads 003h when vecSel is 0 or 007h when vecSel is 1, and sets inService to 1.
- R7: While inService is 1, jumps, calls and plain returns load bit 11 as 0. Bank selects still update the pending flag, and the new flag is used by the first jump after service ends.
- R8: Return-with-restore pops the full 12-bit address, including bit 11, and clears inService.
- R9: The return stack holds 8 entries and wraps circularly. After 9 pushes, 8 pops give the last 8 pushed values, newest first, and a ninth pop gives the newest value again.
- R10: Priority among strobes in one cycle, highest first: interrupt entry, then the returns (either kind), then call, then jump, then increment. With none of them high, fetchAddr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selBank0 | input | 1 | Clear pending bank flag |
| selBank1 | input | 1 | Set pending bank flag |
| doJump | input | 1 | Take a jump to branchTarget |
| doCall | input | 1 | Take a call to branchTarget and push the return address |
| doReturn | input | 1 | Pop the return address |
| doRetRestore | input | 1 | Pop the return address and end interrupt service |
| doIntEntry | input | 1 | Enter interrupt service |
| doIncr | input | 1 | Step to the next sequential address |
| branchTarget | input | 11 | Low bits of a jump or call target |
| vecSel | input | 1 | Interrupt vector pick: 0 gives 003h, 1 gives 007h |
| fetchAddr | output | 12 | Current program fetch address |
| inService | output | 1 | Interrupt service in progress |

## Verification
The hardest case to reach is a bank select issued inside a service routine. Its effect cannot be seen on fetchAddr until the service has ended and a later jump has been taken. To get there, the stimulus first jumps into bank 1 and enters an interrupt. Inside the service routine it jumps and selects a bank, and checks that bit 11 stays 0. It then leaves through return-with-restore and checks that bank 1 comes back. Finally a jump shows which bank flag was set inside the service routine. The stack wrap case is reached with nine calls in a row followed by nine returns.

// File: rtl/bank_pc_pkg.sv
package bank_pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INCR,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_INT
  } pcOpE;

  typedef struct packed {
    pcOpE op;
    logic topBit;     // bit 11 for a jump or call
    logic forceLow;   // clear bit 11 of a popped address
    logic vecSel;
  } pcCtrlS;
endpackage

// File: rtl/bank_pc_stack.sv
module bank_pc_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] topData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrDec;

  assign ptrDec  = ptr - 1'b1;
  assign topData = slots[ptrDec];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[ptr] <= pushData;
      ptr        <= ptr + 1'b1;
    end else if (pop) begin
      ptr <= ptrDec;
    end
  end
endmodule

// File: rtl/bank_pc_ctrl.sv
module bank_pc_ctrl
  import bank_pc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   selBank0,
  input  logic   selBank1,
  input  logic   doJump,
  input  logic   doCall,
  input  logic   doReturn,
  input  logic   doRetRestore,
  input  logic   doIntEntry,
  input  logic   doIncr,
  input  logic   vecSel,
  output pcCtrlS ctrl,
  output logic   inService
);
  logic bankFlag;
  logic svcFlag;
  pcOpE opSel;

  always_comb begin
    if (doIntEntry)                    opSel = OP_INT;
    else if (doReturn || doRetRestore) opSel = OP_RET;
    else if (doCall)                   opSel = OP_CALL;
    else if (doJump)                   opSel = OP_JUMP;
    else if (doIncr)                   opSel = OP_INCR;
    else                               opSel = OP_HOLD;
  end

  always_comb begin
    ctrl.op       = opSel;
    ctrl.topBit   = bankFlag & ~svcFlag;
    ctrl.forceLow = svcFlag & ~doRetRestore;
    ctrl.vecSel   = vecSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankFlag <= 1'b0;
    end else if (selBank1) begin
      bankFlag <= 1'b1;
    end else if (selBank0) begin
      bankFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcFlag <= 1'b0;
    end else if (opSel == OP_INT) begin
      svcFlag <= 1'b1;
    end else if (opSel == OP_RET && doRetRestore) begin
      svcFlag <= 1'b0;
    end
  end

  assign inService = svcFlag;
endmodule

// File: rtl/bank_pc_datapath.sv
module bank_pc_datapath
  import bank_pc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8,
  parameter int VEC_A  = 3,
  parameter int VEC_B  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcCtrlS            ctrl,
  input  logic [ADDR_W-2:0] branchTarget,
  output logic [ADDR_W-1:0] pc
);
  localparam int LOW_W = ADDR_W - 1;

  logic [LOW_W-1:0]  lowNext;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] popAddr;
  logic [ADDR_W-1:0] pushAddr;
  logic [ADDR_W-1:0] pcNext;
  logic              doPush;
  logic              doPop;

  assign lowNext = pc[LOW_W-1:0] + 1'b1;
  assign seqAddr = {pc[ADDR_W-1], lowNext};
  assign doPush  = (ctrl.op == OP_CALL) || (ctrl.op == OP_INT);
  assign doPop   = (ctrl.op == OP_RET);
  assign pushAddr = (ctrl.op == OP_INT) ? pc : seqAddr;

  bank_pc_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (doPush),
    .pop      (doPop),
    .pushData (pushAddr),
    .topData  (popAddr)
  );

  always_comb begin
    unique case (ctrl.op)
      OP_INCR: pcNext = seqAddr;
      OP_JUMP,
      OP_CALL: pcNext = {ctrl.topBit, branchTarget};
      OP_RET:  pcNext = {popAddr[ADDR_W-1] & ~ctrl.forceLow, popAddr[LOW_W-1:0]};
      OP_INT:  pcNext = ctrl.vecSel ? ADDR_W'(VEC_B) : ADDR_W'(VEC_A);
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end
endmodule

// File: rtl/bank_pc_unit.sv
module bank_pc_unit
  import bank_pc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selBank0,
  input  logic              selBank1,
  input  logic              doJump,
  input  logic              doCall,
  input  logic              doReturn,
  input  logic              doRetRestore,
  input  logic              doIntEntry,
  input  logic              doIncr,
  input  logic [ADDR_W-2:0] branchTarget,
  input  logic              vecSel,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              inService
);
  pcCtrlS ctrl;

  bank_pc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .selBank0     (selBank0),
    .selBank1     (selBank1),
    .doJump       (doJump),
    .doCall       (doCall),
    .doReturn     (doReturn),
    .doRetRestore (doRetRestore),
    .doIntEntry   (doIntEntry),
    .doIncr       (doIncr),
    .vecSel       (vecSel),
    .ctrl         (ctrl),
    .inService    (inService)
  );

  bank_pc_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .branchTarget (branchTarget),
    .pc           (fetchAddr)
  );
endmodule

// File: rtl/bank_pc_checker.sv
module bank_pc_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              selBank0,
  input logic              selBank1,
  input logic              doJump,
  input logic              doCall,
  input logic              doReturn,
  input logic              doRetRestore,
  input logic              doIntEntry,
  input logic              doIncr,
  input logic [ADDR_W-2:0] branchTarget,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              inService
);
  localparam int LOW_W = ADDR_W - 1;

  logic anyBranch;
  assign anyBranch = doJump | doCall | doReturn | doRetRestore | doIntEntry;

  // R4: counting stays inside the bank
  p_incr_in_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doIncr && !anyBranch) |=>
      (fetchAddr[ADDR_W-1] == $past(fetchAddr[ADDR_W-1])) &&
      (fetchAddr[LOW_W-1:0] == LOW_W'($past(fetchAddr[LOW_W-1:0]) + 1'b1)));

  // R6: interrupt entry lands on a bank-0 vector with service raised
  p_int_vector_r6: assert property (@(posedge clk) disable iff (!rstN)
    doIntEntry |=> inService &&
      (fetchAddr == ADDR_W'(3) || fetchAddr == ADDR_W'(7)));

  // R7: bank bit held low during service
  p_svc_low_bank_r7: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> (fetchAddr[ADDR_W-1] == 1'b0));

  // R3: branch target reaches the low bits
  p_branch_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((doJump || doCall) && !doReturn && !doRetRestore && !doIntEntry) |=>
      (fetchAddr[LOW_W-1:0] == $past(branchTarget)));

  // R10: no strobe means hold
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!anyBranch && !doIncr) |=> $stable(fetchAddr));

  // R8: return-with-restore ends service
  p_restore_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doRetRestore && !doIntEntry) |=> !inService);
endmodule

bind bank_pc_unit bank_pc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .selBank0     (selBank0),
  .selBank1     (selBank1),
  .doJump       (doJump),
  .doCall       (doCall),
  .doReturn     (doReturn),
  .doRetRestore (doRetRestore),
  .doIntEntry   (doIntEntry),
  .doIncr       (doIncr),
  .branchTarget (branchTarget),
  .fetchAddr    (fetchAddr),
  .inService    (inService)
);

// File: tb/bank_pc_unit_tb.sv
module bank_pc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selBank0 = 0, selBank1 = 0, doJump = 0, doCall = 0;
  logic        doReturn = 0, doRetRestore = 0, doIntEntry = 0, doIncr = 0;
  logic [10:0] branchTarget = '0;
  logic        vecSel = 0;
  logic [11:0] fetchAddr;
  logic        inService;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [11:0] mPc = '0;
  logic        mFlag = 0;
  logic        mSvc = 0;
  logic [11:0] mStack [8];
  int          mPtr = 0;

  bank_pc_unit u_dut (
    .clk(clk), .rstN(rstN), .selBank0(selBank0), .selBank1(selBank1),
    .doJump(doJump), .doCall(doCall), .doReturn(doReturn),
    .doRetRestore(doRetRestore), .doIntEntry(doIntEntry), .doIncr(doIncr),
    .branchTarget(branchTarget), .vecSel(vecSel),
    .fetchAddr(fetchAddr), .inService(inService)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [11:0] expA, input logic expS);
    checks++;
    if (fetchAddr !== expA || inService !== expS) begin
      failures++;
      $display("FAIL %s: fetchAddr=%h inService=%b expected fetchAddr=%h inService=%b",
               tag, fetchAddr, inService, expA, expS);
    end
  endtask

  task automatic mPush(input logic [11:0] v);
    mStack[mPtr] = v;
    mPtr = (mPtr + 1) % 8;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic s0, input logic s1, input logic j, input logic c,
                     input logic r, input logic rr, input logic ie, input logic inc,
                     input logic [10:0] tgt, input logic v, input string tag);
    logic [11:0] popV;
    selBank0 = s0; selBank1 = s1; doJump = j; doCall = c; doReturn = r;
    doRetRestore = rr; doIntEntry = ie; doIncr = inc; branchTarget = tgt; vecSel = v;
    @(posedge clk);
    if (ie) begin
      mPush(mPc);
      mPc = v ? 12'h007 : 12'h003;
      mSvc = 1;
    end else if (r || rr) begin
      mPtr = (mPtr + 7) % 8;
      popV = mStack[mPtr];
      mPc = (mSvc && !rr) ? {1'b0, popV[10:0]} : popV;
      if (rr) mSvc = 0;
    end else if (c || j) begin
      if (c) mPush({mPc[11], mPc[10:0] + 11'd1});
      mPc = {mSvc ? 1'b0 : mFlag, tgt};
    end else if (inc) begin
      mPc = {mPc[11], mPc[10:0] + 11'd1};
    end
    if (s1) mFlag = 1;
    else if (s0) mFlag = 0;
    @(negedge clk);
    check(tag, mPc, mSvc);
    selBank0 = 0; selBank1 = 0; doJump = 0; doCall = 0; doReturn = 0;
    doRetRestore = 0; doIntEntry = 0; doIncr = 0;
  endtask

  task automatic jmp(input logic [10:0] t, input string tag); cyc(0,0,1,0,0,0,0,0,t,0,tag); endtask
  task automatic call(input logic [10:0] t, input string tag); cyc(0,0,0,1,0,0,0,0,t,0,tag); endtask
  task automatic incr(input string tag); cyc(0,0,0,0,0,0,0,1,'0,0,tag); endtask
  task automatic sel(input logic b, input string tag); cyc(!b,b,0,0,0,0,0,0,'0,0,tag); endtask
  task automatic ret(input string tag); cyc(0,0,0,0,1,0,0,0,'0,0,tag); endtask
  task automatic retr(input string tag); cyc(0,0,0,0,0,1,0,0,'0,0,tag); endtask
  task automatic intr(input logic v, input string tag); cyc(0,0,0,0,0,0,1,0,'0,v,tag); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1 reset state", 12'h000, 1'b0);
    jmp(11'h123, "R1 first jump in bank 0");

    sel(1, "R2 select alone holds address");
    jmp(11'h045, "R3 jump to bank 1");
    cyc(1,1,0,0,0,0,0,0,'0,0, "R2 both selects hold address");
    jmp(11'h046, "R2 select1 wins");
    cyc(1,0,1,0,0,0,0,0,11'h050,0, "R2 jump uses old flag");
    jmp(11'h051, "R2 flag cleared afterwards");

    for (int b = 0; b < 2; b++) begin
      for (int t = 0; t < 2048; t += 29) begin
        sel(b[0], "R2 sweep select");
        jmp(11'(t), "R3 sweep jump");
        incr("R4 sweep increment");
      end
    end

    sel(1, "R2 select bank 1");
    jmp(11'h7FF, "R3 jump to top of bank 1");
    incr("R4 wrap stays in bank 1");
    sel(0, "R2 select bank 0");
    jmp(11'h7FF, "R3 jump to top of bank 0");
    incr("R4 wrap stays in bank 0");

    sel(1, "R2 set");
    jmp(11'h010, "R3 into bank 1");
    sel(0, "R2 clear before call");
    call(11'h020, "R3 call to bank 0");
    ret("R5 return restores bank 1");
    jmp(11'h0AA, "R5 flag unchanged by return (0)");
    sel(1, "R2 set before call");
    call(11'h7FF, "R3 call into bank 1");
    call(11'h100, "R3 nested call");
    ret("R5 nested return");
    ret("R5 outer return");
    jmp(11'h0BB, "R5 flag unchanged by return (1)");

    incr("R4 step");
    intr(1, "R6 interrupt vector 007");
    jmp(11'h300, "R7 jump in service stays bank 0");
    call(11'h310, "R7 call in service stays bank 0");
    ret("R7 plain return in service stays bank 0");
    sel(0, "R7 select inside service");
    incr("R7 increment in service");
    retr("R8 restore bank 1 and end service");
    jmp(11'h222, "R7 flag set inside service used after");
    intr(0, "R6 interrupt vector 003");
    sel(1, "R7 select 1 inside service");
    jmp(11'h400, "R7 bank bit held low");
    retr("R8 restore bank 0");
    jmp(11'h401, "R7 pending flag now 1");

    for (int k = 0; k < 9; k++) call(11'(16*k + 5), "R9 push");
    for (int k = 0; k < 9; k++) ret("R9 pop with wrap");

    cyc(0,0,1,1,1,0,1,1,11'h111,1, "R10 interrupt beats all");
    cyc(0,0,1,1,1,0,0,1,11'h112,0, "R10 return beats call");
    cyc(0,0,1,1,0,1,0,1,11'h113,0, "R10 restore beats call");
    cyc(0,0,1,1,0,0,0,1,11'h114,0, "R10 call beats jump");
    ret("R10 call pushed");
    cyc(0,0,1,0,0,0,0,1,11'h115,0, "R10 jump beats increment");
    cyc(0,0,0,0,0,0,0,0,'0,0, "R10 idle hold");
    cyc(0,0,0,0,0,0,0,0,'0,0, "R10 idle hold again");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule